// File: doc/BRIEF.md
# Master-slave down-counter PWM pair

This block makes one pulse-width-modulated output from two coupled down-counters. The master counter sets the period. It loads a period value, counts down to zero, then emits a one-cycle event pulse and reloads itself in the same count step. The slave counter sets the active width. Each master event loads it with a duty value. The output goes active one count clock after the event, and it goes inactive on the count step that finds the slave counter at zero. The slave then idles until the next master event.

A count-clock enable paces both counters, so the block can run from any prescaled rate that the surrounding logic produces. Start and stop are single-cycle trigger pulses that act on both channels together. A trigger is remembered until the next enabled count clock, and takes effect there.

The period and duty inputs may be written at any time. A counter picks up these values only at a master event, so a write in the middle of a cycle changes nothing until the next period begins. When the output enable is low, the pin shows a held value in place of the waveform.

Top module: `ms_pwm_pair`

## Requirements
- R1: While rst_n is low at a clock edge, both counters, the event pulse and the PWM level are cleared to 0, and both channels are left idle.
- R2: The counters and the PWM level change only on clock edges where cnt_en is 1. A start or stop trigger that arrives while cnt_en is 0 is remembered. It acts on the next edge where cnt_en is 1.
- R3: A start acts on its enabled edge. On that edge the master loads period_val and raises irq for one clock cycle. The slave loads duty_val on the same edge.
- R4: While running, the master counts down by one on each enabled edge. On the enabled edge that finds it at 0, it raises irq and reloads period_val. The period is therefore period_val+1 count clocks.
- R5: On each irq edge the slave loads duty_val. From the next enabled edge on, the PWM level is 1 while the slave counts down to 0. On the enabled edge that finds the slave at 0, the level returns to 0. The level is thus active for duty_val count clocks.
- R6: A duty_val of 0 keeps the level at 0 on every count step after the start. A duty_val greater than period_val keeps the level at 1 on every count step after the start.
- R7: A value written to period_val or duty_val in the middle of a period has no effect until the next irq edge.
- R8: A stop acts on both channels on its enabled edge. Both counters keep their values, the PWM level keeps its state, and no irq follows until the next start.
- R9: When out_en is 0, pwm_pin equals out_hold. When out_en is 1, pwm_pin equals the PWM level.
- R10: irq is high for exactly one clock cycle per master event, and only right after an enabled edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_en | input | 1 | Count-clock enable; each high cycle is one count step |
| period_val | input | 16 | Period data value for the master |
| duty_val | input | 16 | Active-width data value for the slave |
| start_trig | input | 1 | One-cycle start trigger for both channels |
| stop_trig | input | 1 | One-cycle stop trigger for both channels |
| out_en | input | 1 | 1 drives the PWM level on the pin; 0 drives out_hold |
| out_hold | input | 1 | Value shown on the pin while out_en is 0 |
| irq | output | 1 | Master event pulse |
| pwm_pin | output | 1 | Output pin level |
| mst_count | output | 16 | Master counter value |
| slv_count | output | 16 | Slave counter value |

## Verification
The assertions guard four things on every cycle:
- The counters stay frozen on cycles with no count step.
- Every master event loads period_val into the master and duty_val into the slave.
- The level falls only from a zero slave count, and rises only from a live count.
- A stop leaves the counters and the level untouched, and an event pulse never appears without a count step.

The true period and width, the constant-inactive and constant-active duty cases, and the deferred pickup of values written mid-cycle can only be seen over whole scenarios. The bench shows them by comparing each count step against expected waveforms. Its directed steps cover triggers deferred while the enable is low, the held state after a stop, and the output-enable mux.

// File: rtl/ms_pwm_pkg.sv
package ms_pwm_pkg;

  // Action a channel takes on one count step
  typedef enum logic [1:0] {
    ACT_IDLE  = 2'd0,
    ACT_HALT  = 2'd1,
    ACT_LOAD  = 2'd2,
    ACT_COUNT = 2'd3
  } ch_act_e;

  // Master decision: stop beats start, start beats normal counting
  function automatic ch_act_e master_act(input logic step, input logic halt,
                                         input logic launch, input logic running,
                                         input logic at_zero);
    if (!step)                      return ACT_IDLE;
    if (halt)                       return ACT_HALT;
    if (launch || (running && at_zero)) return ACT_LOAD;
    if (running)                    return ACT_COUNT;
    return ACT_IDLE;
  endfunction

  // Pin selection between waveform and held value
  function automatic logic pin_level(input logic enable, input logic wave,
                                     input logic held);
    return enable ? wave : held;
  endfunction

endpackage

// File: rtl/ms_pwm_trig.sv
module ms_pwm_trig (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic start_trig,
  input  logic stop_trig,
  output logic go_start,
  output logic go_stop
);

  logic start_pend_q;
  logic stop_pend_q;
  logic want_start;
  logic want_stop;

  assign want_start = start_pend_q | start_trig;
  assign want_stop  = stop_pend_q | stop_trig;
  assign go_stop    = tick & want_stop;
  assign go_start   = tick & want_start & ~want_stop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_pend_q <= 1'b0;
      stop_pend_q  <= 1'b0;
    end else if (tick) begin
      start_pend_q <= 1'b0;
      stop_pend_q  <= 1'b0;
    end else begin
      start_pend_q <= want_start;
      stop_pend_q  <= want_stop;
    end
  end

endmodule

// File: rtl/ms_pwm_master.sv
module ms_pwm_master
  import ms_pwm_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             go_start,
  input  logic             go_stop,
  input  logic [CNT_W-1:0] period_val,
  output logic             fire,
  output logic             irq,
  output logic [CNT_W-1:0] cnt_q
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] v);
    return v - ONE;
  endfunction

  logic    run_q;
  logic    at_zero;
  ch_act_e act;

  assign at_zero = (cnt_q == '0);
  assign act     = master_act(tick, go_stop, go_start, run_q, at_zero);
  assign fire    = (act == ACT_LOAD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      irq   <= 1'b0;
    end else begin
      irq <= fire;
      unique case (act)
        ACT_HALT:  run_q <= 1'b0;
        ACT_LOAD:  begin
          run_q <= 1'b1;
          cnt_q <= period_val;
        end
        ACT_COUNT: cnt_q <= step_down(cnt_q);
        default:   ;
      endcase
    end
  end

  logic past_ok;
  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R4: an event reloads the period value
  p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(fire) |-> cnt_q == $past(period_val));

  // R2: no count step, no counter change
  p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && !$past(tick) |-> $stable(cnt_q));

  // R8: stop keeps the count
  p_stop_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(go_stop) |-> $stable(cnt_q) && !irq);

  // R10: event pulse only after a count step
  p_irq_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && irq |-> $past(tick));

endmodule

// File: rtl/ms_pwm_slave.sv
module ms_pwm_slave #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             go_stop,
  input  logic             fire,
  input  logic [CNT_W-1:0] duty_val,
  output logic             lvl_q,
  output logic [CNT_W-1:0] cnt_q
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] v);
    return v - ONE;
  endfunction

  logic run_q;
  logic at_zero;
  logic expire;
  logic advance;

  assign at_zero = (cnt_q == '0);
  assign expire  = tick & ~go_stop & run_q & at_zero;
  assign advance = tick & ~go_stop & run_q & ~at_zero;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      lvl_q <= 1'b0;
      cnt_q <= '0;
    end else if (tick) begin
      if (go_stop) begin
        run_q <= 1'b0;
      end else begin
        if (expire) begin
          lvl_q <= 1'b0;
          run_q <= 1'b0;
        end else if (advance) begin
          lvl_q <= 1'b1;
          cnt_q <= step_down(cnt_q);
        end
        if (fire) begin
          cnt_q <= duty_val;
          run_q <= 1'b1;
        end
      end
    end
  end

  logic past_ok;
  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R5: each master event loads the duty value
  p_duty_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(fire) |-> cnt_q == $past(duty_val));

  // R5: level falls only from a zero slave count
  p_fall_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $fell(lvl_q) |-> $past(cnt_q) == '0);

  // R5: level rises only from a live nonzero count
  p_rise_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $rose(lvl_q) |-> $past(run_q) && $past(cnt_q) != '0);

  // R8: stop keeps the level and the count
  p_stop_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(go_stop) |-> $stable(lvl_q) && $stable(cnt_q));

  // R2: no count step, no level change
  p_level_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && !$past(tick) |-> $stable(lvl_q));

endmodule

// File: rtl/ms_pwm_pair.sv
module ms_pwm_pair
  import ms_pwm_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic [CNT_W-1:0] period_val,
  input  logic [CNT_W-1:0] duty_val,
  input  logic             start_trig,
  input  logic             stop_trig,
  input  logic             out_en,
  input  logic             out_hold,
  output logic             irq,
  output logic             pwm_pin,
  output logic [CNT_W-1:0] mst_count,
  output logic [CNT_W-1:0] slv_count
);

  logic go_start;
  logic go_stop;
  logic mst_fire;
  logic pwm_lvl;

  ms_pwm_trig u_trig (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (cnt_en),
    .start_trig (start_trig),
    .stop_trig  (stop_trig),
    .go_start   (go_start),
    .go_stop    (go_stop)
  );

  ms_pwm_master #(.CNT_W(CNT_W)) u_master (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (cnt_en),
    .go_start   (go_start),
    .go_stop    (go_stop),
    .period_val (period_val),
    .fire       (mst_fire),
    .irq        (irq),
    .cnt_q      (mst_count)
  );

  ms_pwm_slave #(.CNT_W(CNT_W)) u_slave (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (cnt_en),
    .go_stop  (go_stop),
    .fire     (mst_fire),
    .duty_val (duty_val),
    .lvl_q    (pwm_lvl),
    .cnt_q    (slv_count)
  );

  assign pwm_pin = pin_level(out_en, pwm_lvl, out_hold);

endmodule

// File: tb/ms_pwm_pair_bench.sv
module ms_pwm_pair_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b0;
  logic [15:0] period_val = '0;
  logic [15:0] duty_val = '0;
  logic        start_trig = 1'b0;
  logic        stop_trig = 1'b0;
  logic        out_en = 1'b1;
  logic        out_hold = 1'b0;
  logic        irq;
  logic        pwm_pin;
  logic [15:0] mst_count;
  logic [15:0] slv_count;

  ms_pwm_pair u_ms_pwm_pair (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .period_val(period_val),
    .duty_val(duty_val), .start_trig(start_trig), .stop_trig(stop_trig),
    .out_en(out_en), .out_hold(out_hold), .irq(irq), .pwm_pin(pwm_pin),
    .mst_count(mst_count), .slv_count(slv_count)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic        lvl;
    logic        ev;
    logic [15:0] m;
    logic [15:0] s;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_errors = 0;
  bit   done = 1'b0;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  // Expected steps of one period: phase 0 is the event step
  function automatic logic push_cycle(input int p, input int d, input logic lvl0);
    for (int ph = 0; ph <= p; ph++) begin
      exp_t e;
      e.ev  = (ph == 0);
      e.m   = 16'(p - ph);
      e.s   = (ph == 0) ? 16'(d) : ((d > ph) ? 16'(d - ph) : 16'd0);
      e.lvl = (ph == 0) ? lvl0 : (ph <= d);
      exp_q.push_back(e);
    end
    return (d > p);
  endfunction

  // Monitor: one expected item per enabled step
  always @(posedge clk) begin
    #1;
    if (cnt_en && exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      chk("R5 R6 pwm level", 16'(pwm_pin), 16'(e.lvl));
      chk("R4 R7 master count", mst_count, e.m);
      chk("R5 R7 slave count", slv_count, e.s);
      chk("R3 R10 event pulse", 16'(irq), 16'(e.ev));
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic l;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1 master count", mst_count, 16'd0);
    chk("R1 slave count", slv_count, 16'd0);
    chk("R1 pwm", 16'(pwm_pin), 16'd0);
    chk("R1 irq", 16'(irq), 16'd0);

    // Scoreboard scenario: period 4 duty 2, then 2/5, then 2/0
    @(negedge clk);
    rst_n = 1'b1;
    cnt_en = 1'b1;
    period_val = 16'd4;
    duty_val = 16'd2;
    l = push_cycle(4, 2, 1'b0);
    l = push_cycle(4, 2, l);
    l = push_cycle(2, 5, l);
    l = push_cycle(2, 5, l);
    l = push_cycle(2, 0, l);
    l = push_cycle(2, 0, l);
    start_trig = 1'b1;
    @(negedge clk);
    start_trig = 1'b0;
    repeat (7) @(negedge clk);
    period_val = 16'd2;   // R7: written mid-period, used from step 10
    duty_val = 16'd5;
    repeat (7) @(negedge clk);
    duty_val = 16'd0;     // R6: duty 0 from step 16
    wait (exp_q.size() == 0);

    // Restart with period 6 duty 4
    @(negedge clk);
    period_val = 16'd6;
    duty_val = 16'd4;
    start_trig = 1'b1;
    step();
    start_trig = 1'b0;
    chk("R3 start irq", 16'(irq), 16'd1);
    chk("R3 start master load", mst_count, 16'd6);
    step();
    step();
    chk("R5 level active", 16'(pwm_pin), 16'd1);
    chk("R4 master after two steps", mst_count, 16'd4);

    // R2: stop deferred while the enable is low
    @(negedge clk);
    cnt_en = 1'b0;
    stop_trig = 1'b1;
    step();
    stop_trig = 1'b0;
    step();
    step();
    chk("R2 master frozen", mst_count, 16'd4);
    chk("R2 slave frozen", slv_count, 16'd2);
    @(negedge clk);
    cnt_en = 1'b1;
    step();
    @(negedge clk);
    cnt_en = 1'b1;
    repeat (5) step();
    chk("R8 master held", mst_count, 16'd4);
    chk("R8 slave held", slv_count, 16'd2);
    chk("R8 level held", 16'(pwm_pin), 16'd1);
    chk("R8 no irq", 16'(irq), 16'd0);

    // R9: output enable mux
    @(negedge clk);
    out_en = 1'b0;
    out_hold = 1'b0;
    #1;
    chk("R9 held 0", 16'(pwm_pin), 16'd0);
    out_hold = 1'b1;
    #1;
    chk("R9 held 1", 16'(pwm_pin), 16'd1);
    out_en = 1'b1;
    out_hold = 1'b0;
    #1;
    chk("R9 waveform back", 16'(pwm_pin), 16'd1);

    // R2: start deferred while the enable is low
    @(negedge clk);
    cnt_en = 1'b0;
    start_trig = 1'b1;
    step();
    start_trig = 1'b0;
    step();
    chk("R2 no early irq", 16'(irq), 16'd0);
    chk("R2 no early load", mst_count, 16'd4);
    @(negedge clk);
    cnt_en = 1'b1;
    step();
    chk("R2 deferred start irq", 16'(irq), 16'd1);
    chk("R3 deferred master load", mst_count, 16'd6);
    chk("R3 deferred slave load", slv_count, 16'd4);
    @(negedge clk);
    cnt_en = 1'b0;
    step();
    chk("R10 irq one cycle", 16'(irq), 16'd0);
    chk("R2 count frozen", mst_count, 16'd6);

    finish_run();
  end

endmodule